// File: doc/BRIEF.md
# SPI Two-Frame Register Access Master

This block is an SPI master that lets on-chip logic write and read 16-bit registers in one external slave. Every transfer on the wire is a 24-bit frame. The frame holds a command byte, whose top bit selects read, above a 7-bit register address, followed by 16 data bits. A write is a single frame. A read needs two frames. The first frame carries the read command. The slave answers in the second frame, which is an all-zero no-operation word. What the slave shifts back during the command frame is stale, often an echo of the previous frame, so the block discards it.

The host side is a plain strobe interface. The host pulses a request with a read flag, an address and write data. It then watches busy and waits for a one-cycle done pulse. For reads, the captured register value is presented with that pulse. The serial clock is derived from the system clock by a parameterised divider. The divider is clamped so that the serial clock never exceeds the configured maximum rate.

Top module: `spi2f_reg_master`

## Requirements
- R1: While reset is held and in the first cycle after it, cs_n is 1, sclk is 0, mosi is 0, busy is 0 and done is 0.
- R2: A write request (is_read=0) sends exactly one frame whose 24 bits are {1'b0, addr[6:0], wdata[15:0]}, most significant bit first, and then pulses done with no further frame.
- R3: A read request (is_read=1) sends exactly two frames. The first is {1'b1, addr[6:0], 16'h0000}, e.g. 24'h8B0000 for address 0x0B. The second is 24'h000000.
- R4: On a read, rdata equals the lower 16 bits shifted in on miso during the second frame. Bits received during the command frame have no effect on rdata.
- R5: sclk idles low and is only high while cs_n is low. mosi changes only on a rising sclk edge, and miso is sampled on the falling edge (mode with CPOL=0, CPHA=1).
- R6: Between the two frames of a read, cs_n returns high for at least CS_GAP (default 2) system clocks.
- R7: Each sclk half period lasts max(HALF_DIV, ceil(SYS_CLK_HZ / (2*SCLK_MAX_HZ))) system clocks. With the defaults of 200 MHz and 25 MHz, that is at least 4 clocks.
- R8: done is a single-cycle pulse. busy is high from the cycle after an accepted request up to the done cycle, and busy is low while done is high.
- R9: A request that arrives while busy is high is ignored. It starts no frame and changes neither registers nor rdata.
- R10: A request presented in the same cycle as done is accepted and starts a new transaction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Transaction request strobe |
| is_read | input | 1 | 1 = register read, 0 = register write |
| addr | input | ADDR_W | Register address |
| wdata | input | DATA_W | Data for a write |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Read result, valid with done after a read |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to slave |
| miso | input | 1 | Serial data from slave |
| cs_n | output | 1 | Active-low chip select |

## Verification
The completion pulse and the acceptance of a new request can land in the same cycle, because busy drops exactly when done rises. The bench provokes this by raising req in the very cycle it sees done. It judges the outcome by the slave model recording a fresh write frame with the new address and data, followed by a second done. It also places a conflicting request in the middle of a read. There it confirms that only the read's two frames appear and that a later read of the target register shows it unchanged.

// File: rtl/spi2f_pkg.sv
// Package spi2f_pkg
// Shared state encodings for the two-frame SPI register master.
// Assumes: one slave, fixed frame layout {rw, addr, data}.
package spi2f_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_CMD  = 2'd1,
        SEQ_GAP  = 2'd2,
        SEQ_NOP  = 2'd3
    } seq_state_t;

    typedef enum logic [1:0] {
        FRM_IDLE = 2'd0,
        FRM_LEAD = 2'd1,
        FRM_RUN  = 2'd2,
        FRM_TAIL = 2'd3
    } frm_state_t;

endpackage

// File: rtl/spi2f_tick.sv
// Module spi2f_tick
// Emits a one-cycle tick every HALF system clocks while enabled.
// The counter restarts from zero whenever the enable drops.
// Assumes: HALF >= 1.
module spi2f_tick #(
    parameter int HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF + 1) : 1;

    logic [CW-1:0] cnt;

    assign tick = en && (cnt == CW'(HALF - 1));

    // count system clocks within one sclk half period
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/spi2f_frame.sv
// Module spi2f_frame
// Shifts one FW-bit frame out on mosi and in from miso, MSB first,
// in SPI mode CPOL=0 / CPHA=1. A lead half period follows the falling
// cs_n edge, and a tail half period precedes the rising edge.
// Assumes: start only arrives while run is low; tick comes from spi2f_tick.
module spi2f_frame
    import spi2f_pkg::*;
#(
    parameter int FW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [FW-1:0] word_in,
    input  logic          tick,
    output logic          run,
    output logic          sclk,
    output logic          mosi,
    output logic          cs_n,
    input  logic          miso,
    output logic [FW-1:0] rx_word,
    output logic          frame_done
);
    localparam int BW = $clog2(FW);

    frm_state_t    st;
    logic [FW-1:0] tx_sr;
    logic [BW-1:0] bit_cnt;

    assign run = (st != FRM_IDLE);

    // frame state machine, serial pins and shift registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= FRM_IDLE;
            sclk       <= 1'b0;
            mosi       <= 1'b0;
            cs_n       <= 1'b1;
            tx_sr      <= '0;
            rx_word    <= '0;
            bit_cnt    <= '0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            case (st)
                FRM_IDLE: if (start) begin
                    st      <= FRM_LEAD;
                    cs_n    <= 1'b0;
                    tx_sr   <= word_in;
                    bit_cnt <= '0;
                end
                FRM_LEAD: if (tick) st <= FRM_RUN;
                FRM_RUN: if (tick) begin
                    if (!sclk) begin
                        sclk  <= 1'b1;
                        mosi  <= tx_sr[FW-1];
                        tx_sr <= {tx_sr[FW-2:0], 1'b0};
                    end else begin
                        sclk    <= 1'b0;
                        rx_word <= {rx_word[FW-2:0], miso};
                        if (bit_cnt == BW'(FW - 1)) st <= FRM_TAIL;
                        else bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                FRM_TAIL: if (tick) begin
                    st         <= FRM_IDLE;
                    cs_n       <= 1'b1;
                    frame_done <= 1'b1;
                end
                default: st <= FRM_IDLE;
            endcase
        end
    end

    AST_SCLK_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !cs_n); // R5
    AST_MOSI_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mosi) |-> $rose(sclk)); // R5

endmodule

// File: rtl/spi2f_reg_master.sv
// Module spi2f_reg_master
// Host-facing sequencer. A write sends one frame. A read sends a command
// frame, holds cs_n high for CS_GAP clocks, then sends an all-zero frame,
// and returns the low data bits captured during that second frame.
// Assumes: ADDR_W = 7 so the command byte is {rw, addr}.
// The sclk half period is clamped to respect SCLK_MAX_HZ.
module spi2f_reg_master
    import spi2f_pkg::*;
#(
    parameter int SYS_CLK_HZ  = 200_000_000,
    parameter int SCLK_MAX_HZ = 25_000_000,
    parameter int HALF_DIV    = 4,
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 16,
    parameter int CS_GAP      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              is_read,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              cs_n
);
    localparam int FW       = 1 + ADDR_W + DATA_W;
    localparam int HALF_MIN = (SYS_CLK_HZ + 2 * SCLK_MAX_HZ - 1) / (2 * SCLK_MAX_HZ);
    localparam int HALF     = (HALF_DIV > HALF_MIN) ? HALF_DIV : HALF_MIN;
    localparam int GW       = (CS_GAP > 1) ? $clog2(CS_GAP + 1) : 1;

    seq_state_t     st;
    logic           rd_q;
    logic           start;
    logic [FW-1:0]  word;
    logic [GW-1:0]  gap_cnt;
    logic           run;
    logic           tick;
    logic           frame_done;
    logic [FW-1:0]  rx_word;

    assign busy = (st != SEQ_IDLE);

    spi2f_tick #(.HALF(HALF)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (run),
        .tick  (tick)
    );

    spi2f_frame #(.FW(FW)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .word_in    (word),
        .tick       (tick),
        .run        (run),
        .sclk       (sclk),
        .mosi       (mosi),
        .cs_n       (cs_n),
        .miso       (miso),
        .rx_word    (rx_word),
        .frame_done (frame_done)
    );

    // transaction sequencer: accept, command frame, gap, no-op frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= SEQ_IDLE;
            rd_q    <= 1'b0;
            start   <= 1'b0;
            word    <= '0;
            gap_cnt <= '0;
            done    <= 1'b0;
            rdata   <= '0;
        end else begin
            start <= 1'b0;
            done  <= 1'b0;
            case (st)
                SEQ_IDLE: if (req) begin
                    st    <= SEQ_CMD;
                    rd_q  <= is_read;
                    start <= 1'b1;
                    word  <= is_read ? {1'b1, addr, {DATA_W{1'b0}}}
                                     : {1'b0, addr, wdata};
                end
                SEQ_CMD: if (frame_done) begin
                    gap_cnt <= '0;
                    if (rd_q) begin
                        st <= SEQ_GAP;
                    end else begin
                        st   <= SEQ_IDLE;
                        done <= 1'b1;
                    end
                end
                SEQ_GAP: begin
                    if (gap_cnt == GW'(CS_GAP - 1)) begin
                        st    <= SEQ_NOP;
                        start <= 1'b1;
                        word  <= '0;
                    end else begin
                        gap_cnt <= gap_cnt + 1'b1;
                    end
                end
                SEQ_NOP: if (frame_done) begin
                    st    <= SEQ_IDLE;
                    rdata <= rx_word[DATA_W-1:0];
                    done  <= 1'b1;
                end
                default: st <= SEQ_IDLE;
            endcase
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R8
    AST_CS_HIGH_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |=> cs_n); // R6
    AST_REQ_BUSY_NOSTART: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !frame_done && st != SEQ_GAP) |=> $stable(word)); // R9

endmodule

// File: tb/spi2f_reg_master_test.sv
`timescale 1ns/1ps
module spi2f_reg_master_test;

    localparam int SYS_HZ   = 200_000_000;
    localparam int MAX_HZ   = 25_000_000;
    localparam int HDIV     = 2;
    localparam int HALF_EXP = ((SYS_HZ + 2 * MAX_HZ - 1) / (2 * MAX_HZ) > HDIV)
                              ? (SYS_HZ + 2 * MAX_HZ - 1) / (2 * MAX_HZ) : HDIV;
    localparam int GAP      = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        is_read = 1'b0;
    logic [6:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic        busy, done, sclk, mosi, cs_n;
    logic [15:0] rdata;
    logic        miso = 1'b0;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    spi2f_reg_master #(
        .SYS_CLK_HZ(SYS_HZ), .SCLK_MAX_HZ(MAX_HZ), .HALF_DIV(HDIV),
        .ADDR_W(7), .DATA_W(16), .CS_GAP(GAP)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req(req), .is_read(is_read), .addr(addr),
        .wdata(wdata), .busy(busy), .done(done), .rdata(rdata), .sclk(sclk),
        .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    // ---------------- slave model ----------------
    logic [15:0] sregs [128];
    logic [23:0] s_in = '0;
    logic [23:0] s_out = '0;
    logic [23:0] frames [4];
    int          nfr = 0;
    bit          slave_on = 0;

    always @(posedge sclk) begin
        miso  <= s_out[23];
        s_out <= {s_out[22:0], 1'b0};
    end
    always @(negedge sclk) s_in <= {s_in[22:0], mosi};
    always @(posedge cs_n) begin
        if (slave_on) begin
            if (nfr < 4) frames[nfr] = s_in;
            nfr = nfr + 1;
            if (s_in[23]) begin
                s_out = {8'h00, sregs[s_in[22:16]]};
            end else begin
                if (s_in != 24'h0) sregs[s_in[22:16]] = s_in[15:0];
                s_out = ~s_in;   // stale echo, must never reach rdata
            end
        end
    end

    // ---------------- timing monitors ----------------
    int hi_len = 0, hi_min = 1000, hi_max = 0;
    int cs_hi = 0, gap_seen = 0;
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (sclk) hi_len = hi_len + 1;
        else if (hi_len != 0) begin
            if (hi_len < hi_min) hi_min = hi_len;
            if (hi_len > hi_max) hi_max = hi_len;
            hi_len = 0;
        end
        if (cs_n) cs_hi = cs_hi + 1;
        else begin
            if (cs_hi != 0 && nfr == 1) gap_seen = cs_hi;
            cs_hi = 0;
        end
        if (cyc > 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: cycles=%0d expected<=150000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(done, "R8 done timeout", {31'b0, done}, 32'd1);
    endtask

    task automatic issue(input bit rd, input logic [6:0] a, input logic [15:0] d);
        @(negedge clk);
        req = 1'b1; is_read = rd; addr = a; wdata = d;
        nfr = 0; gap_seen = 0;
        @(negedge clk);
        req = 1'b0;
    endtask

    // {is_read, addr[6:0], wdata[15:0], expected rdata[15:0]}
    localparam logic [39:0] VEC [8] = '{
        {1'b0, 7'h05, 16'h1234, 16'h0000},
        {1'b1, 7'h05, 16'h0000, 16'h1234},
        {1'b1, 7'h0B, 16'h0000, 16'h010F},
        {1'b0, 7'h7F, 16'hFFFF, 16'h0000},
        {1'b1, 7'h7F, 16'h0000, 16'hFFFF},
        {1'b0, 7'h00, 16'h8001, 16'h0000},
        {1'b1, 7'h00, 16'h0000, 16'h8001},
        {1'b1, 7'h05, 16'h0000, 16'h1234}
    };

    initial begin
        for (int i = 0; i < 128; i++) sregs[i] = {i[7:0], ~i[7:0]};
        sregs[11] = 16'h010F;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(cs_n === 1'b1 && sclk === 1'b0 && mosi === 1'b0, "R1 pins in reset",
            {29'b0, cs_n, sclk, mosi}, 32'h4);
        chk(busy === 1'b0 && done === 1'b0, "R1 busy/done in reset",
            {30'b0, busy, done}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        slave_on = 1;
        chk(cs_n === 1'b1 && sclk === 1'b0 && busy === 1'b0, "R1 after reset",
            {29'b0, cs_n, sclk, busy}, 32'h4);

        // table walk: R2, R3, R4, R6
        for (int v = 0; v < 8; v++) begin
            logic [39:0] e;
            e = VEC[v];
            issue(e[39], e[38:32], e[31:16]);
            chk(busy === 1'b1, "R8 busy after accept", {31'b0, busy}, 32'd1);
            wait_done();
            chk(busy === 1'b0, "R8 busy low with done", {31'b0, busy}, 32'd0);
            @(negedge clk);
            chk(done === 1'b0, "R8 done one cycle", {31'b0, done}, 32'd0);
            repeat (4) @(negedge clk);
            if (e[39]) begin
                chk(nfr == 2, "R3 read frame count", nfr, 2);
                chk(frames[0] == {1'b1, e[38:32], 16'h0}, "R3 read command frame",
                    {8'b0, frames[0]}, {8'b0, 1'b1, e[38:32], 16'h0});
                chk(frames[1] == 24'h0, "R3 no-op frame", {8'b0, frames[1]}, 32'h0);
                chk(rdata == e[15:0], "R4 read data", {16'b0, rdata}, {16'b0, e[15:0]});
                chk(gap_seen >= GAP, "R6 cs high gap", gap_seen, GAP);
            end else begin
                chk(nfr == 1, "R2 write frame count", nfr, 1);
                chk(frames[0] == {1'b0, e[38:32], e[31:16]}, "R2 write frame",
                    {8'b0, frames[0]}, {8'b0, 1'b0, e[38:32], e[31:16]});
            end
        end

        // R7: sclk half period
        chk(hi_min == HALF_EXP && hi_max == HALF_EXP, "R7 sclk high time",
            hi_min, HALF_EXP);
        // R5: idle levels between transactions
        chk(sclk === 1'b0 && cs_n === 1'b1, "R5 idle sclk low", {30'b0, sclk, cs_n}, 32'h1);

        // R9: conflicting request during a read is ignored
        issue(1'b1, 7'h0B, 16'h0);
        repeat (60) @(negedge clk);
        req = 1'b1; is_read = 1'b0; addr = 7'h22; wdata = 16'hDEAD;
        @(negedge clk);
        req = 1'b0;
        wait_done();
        chk(rdata == 16'h010F, "R9 read unaffected", {16'b0, rdata}, 32'h010F);
        repeat (4) @(negedge clk);
        chk(nfr == 2, "R9 no extra frame", nfr, 2);
        issue(1'b1, 7'h22, 16'h0);
        wait_done();
        chk(rdata == 16'h22DD, "R9 target register untouched", {16'b0, rdata}, 32'h22DD);

        // R10: request in the done cycle is accepted
        issue(1'b0, 7'h30, 16'h5A5A);
        wait_done();
        req = 1'b1; is_read = 1'b0; addr = 7'h31; wdata = 16'hA5A5;
        nfr = 0;
        @(negedge clk);
        req = 1'b0;
        chk(busy === 1'b1, "R10 accepted in done cycle", {31'b0, busy}, 32'd1);
        wait_done();
        repeat (4) @(negedge clk);
        chk(nfr == 1 && frames[0] == {1'b0, 7'h31, 16'hA5A5}, "R10 back-to-back frame",
            {8'b0, frames[0]}, {8'b0, 1'b0, 7'h31, 16'hA5A5});

        // R4: stale echo during the command frame must not leak into rdata
        issue(1'b1, 7'h31, 16'h0);
        wait_done();
        chk(rdata == 16'hA5A5, "R4 echo discarded", {16'b0, rdata}, 32'hA5A5);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule